// File: doc/BRIEF.md
# Ethernet Pause Flow-Control Controller

This block handles full-duplex Pause flow control for an Ethernet MAC, both sending and receiving. On the send side it decides when a Pause control frame must go out and which quanta value it carries. Requests come from three places: a software initiate pulse, the rising and falling edges of a receive-FIFO congestion level, and an automatic refresh that re-sends the Pause frame before the advertised pause runs out. A downstream frame builder takes the request (`send_req` and `send_quanta`) and reports the end of the frame with `send_done`. A busy flag shows that a software-requested frame is still pending or in flight.

On the receive side, a frame parser presents the destination address, EtherType, opcode and pause quanta of each received frame for one cycle. When the frame is a valid Pause frame, the block loads a countdown that is clocked by an external slot-time pulse (one pulse per 512 bit times). While the count is nonzero, `tx_paused` stays high so that the transmit scheduler holds back new data frames. Byte serialization, CRC and line timing are not part of this block.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, `send_req`, `busy` and `tx_paused` are all 0.
- R2: A `sw_init` pulse taken while sending is allowed sets `busy` on the next edge and queues one Pause frame carrying `pause_time`. `busy` stays 1 until a `send_done` completes a frame with nothing left queued.
- R3: A queued frame is launched when `send_req` is low by raising `send_req` one edge later. `send_req` and `send_quanta` then hold steady until `send_done` is seen high while `send_req` is high, which lowers `send_req` on that edge.
- R4: Sending is allowed only when both `tx_fc_en` and `full_duplex` are 1. Otherwise, `sw_init` and every FIFO-driven event queue nothing and do not set `busy`.
- R5: A rising edge on `fifo_fc_req` queues a Pause frame carrying `pause_time`.
- R6: Consider a frame with nonzero quanta that completes while `fifo_fc_req` is high. The refresh delay is `pause_time` minus an offset selected by `thr_code`: code 0 gives 4, code 1 gives 28, code 2 gives 144 and code 3 gives 256. The slot tick that ends this delay, counted from the completion, queues another frame carrying `pause_time`. When `pause_time` is not greater than the offset, no refresh is armed.
- R7: A falling edge on `fifo_fc_req` cancels any armed refresh and queues a frame with quanta 0, unless `zq_disable` is 1.
- R8: A received frame is accepted as Pause when `rx_valid`, `full_duplex`, `rx_fc_en`, type 0x8808 and opcode 0x0001 all hold and the DA is 01-80-C2-00-00-01. On acceptance, `tx_paused` rises on the next edge and stays high for exactly `rx_quanta` slot ticks.
- R9: A DA equal to `station_addr` is accepted in place of the multicast address only when `uni_pause_en` is 1.
- R10: An accepted frame reloads the pause count with its quanta even if a pause is already running. Quanta 0 therefore ends a pause on the next edge.
- R11: A received frame that fails any condition of R8 or R9 leaves `tx_paused` and the pause count unchanged.
- R12: When two requests meet in the same cycle, `sw_init` takes priority over FIFO events. A newer request overwrites the value of a frame still waiting to launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | Link is full duplex |
| tx_fc_en | input | 1 | Allows Pause frame generation |
| rx_fc_en | input | 1 | Allows Pause frame decoding |
| uni_pause_en | input | 1 | Also accepts Pause addressed to the station |
| zq_disable | input | 1 | Suppresses the zero-quanta frame on release |
| thr_code | input | 2 | Refresh offset select |
| pause_time | input | QW | Quanta for outgoing Pause frames |
| station_addr | input | AW | Station unicast address |
| sw_init | input | 1 | Software initiate pulse |
| busy | output | 1 | Software request pending or in flight |
| fifo_fc_req | input | 1 | FIFO congestion level |
| slot_tick | input | 1 | One pulse per slot time |
| send_req | output | 1 | Pause frame send request |
| send_quanta | output | QW | Quanta for the requested frame |
| send_done | input | 1 | Requested frame finished |
| rx_valid | input | 1 | Parsed receive fields valid |
| rx_da | input | AW | Received destination address |
| rx_type | input | 16 | Received EtherType |
| rx_opcode | input | 16 | Received control opcode |
| rx_quanta | input | QW | Received pause quanta |
| tx_paused | output | 1 | Transmitter held off |

## Verification
The hardest case to reach is the automatic refresh, because it needs three things in order: a FIFO rise, a completed nonzero frame with the level still held, and then exactly the counted number of slot ticks. The stimulus sets small pause times against each offset code, completes the frame by hand and then clocks ticks one by one. It checks that `send_req` stays low up to the last tick and rises just after it. A long random phase also mixes completions, ticks, FIFO edges and receive frames so that refreshes collide with releases and re-requests, and a behavioural model follows every cycle.

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
  parameter int QW = 16,
  parameter int AW = 48,
  parameter logic [AW-1:0] PAUSE_DA = 48'h0180C2000001,
  parameter logic [15:0] CTRL_TYPE = 16'h8808,
  parameter logic [15:0] PAUSE_OP = 16'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_duplex,
  input  logic          tx_fc_en,
  input  logic          rx_fc_en,
  input  logic          uni_pause_en,
  input  logic          zq_disable,
  input  logic [1:0]    thr_code,
  input  logic [QW-1:0] pause_time,
  input  logic [AW-1:0] station_addr,
  input  logic          sw_init,
  output logic          busy,
  input  logic          fifo_fc_req,
  input  logic          slot_tick,
  output logic          send_req,
  output logic [QW-1:0] send_quanta,
  input  logic          send_done,
  input  logic          rx_valid,
  input  logic [AW-1:0] rx_da,
  input  logic [15:0]   rx_type,
  input  logic [15:0]   rx_opcode,
  input  logic [QW-1:0] rx_quanta,
  output logic          tx_paused
);

  logic          fifo_q;
  logic          pend_v;
  logic [QW-1:0] pend_q;
  logic [QW-1:0] rcnt;
  logic [QW-1:0] pcnt;
  logic [QW:0]   off;

  always_comb begin
    case (thr_code)
      2'd0:    off = (QW+1)'(4);
      2'd1:    off = (QW+1)'(28);
      2'd2:    off = (QW+1)'(144);
      default: off = (QW+1)'(256);
    endcase
  end

  wire          en       = tx_fc_en & full_duplex;
  wire          fc_rise  = fifo_fc_req & ~fifo_q;
  wire          fc_fall  = ~fifo_fc_req & fifo_q;
  wire          resend   = slot_tick & (rcnt == QW'(1)) & fifo_fc_req;
  wire          sw_go    = sw_init & en;
  wire          pt_go    = sw_go | ((fc_rise | resend) & en);
  wire          zq_go    = fc_fall & en & ~zq_disable;
  wire          ins      = pt_go | zq_go;
  wire [QW-1:0] ins_q    = pt_go ? pause_time : '0;
  wire          done_hit = send_req & send_done;
  wire          launch   = ~send_req & pend_v;
  wire          pend_nxt = ins | (pend_v & ~launch);
  wire [QW:0]   pt_ext   = {1'b0, pause_time};
  wire          arm      = done_hit & (send_quanta != '0) & fifo_fc_req & (pt_ext > off);
  wire [QW:0]   reload   = pt_ext - off;

  wire da_ok  = (rx_da == PAUSE_DA) | (uni_pause_en & (rx_da == station_addr));
  wire rx_hit = rx_valid & full_duplex & rx_fc_en & (rx_type == CTRL_TYPE) &
                (rx_opcode == PAUSE_OP) & da_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_q      <= 1'b0;
      pend_v      <= 1'b0;
      pend_q      <= '0;
      send_req    <= 1'b0;
      send_quanta <= '0;
      busy        <= 1'b0;
      rcnt        <= '0;
    end else begin
      fifo_q <= fifo_fc_req;
      pend_v <= pend_nxt;
      if (ins) pend_q <= ins_q;
      if (launch) begin
        send_req    <= 1'b1;
        send_quanta <= pend_q;
      end else if (done_hit) begin
        send_req <= 1'b0;
      end
      if (sw_go) busy <= 1'b1;
      else if (done_hit && !pend_nxt) busy <= 1'b0;
      if (fc_fall) rcnt <= '0;
      else if (arm) rcnt <= reload[QW-1:0];
      else if (done_hit) rcnt <= '0;
      else if (slot_tick && rcnt != '0) rcnt <= rcnt - QW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= '0;
    else if (rx_hit) pcnt <= rx_quanta;
    else if (slot_tick && pcnt != '0) pcnt <= pcnt - QW'(1);
  end

  assign tx_paused = (pcnt != '0);

endmodule

module pause_flow_ctrl_chk #(
  parameter int QW = 16,
  parameter int AW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          full_duplex,
  input logic          tx_fc_en,
  input logic          rx_fc_en,
  input logic          sw_init,
  input logic          busy,
  input logic          slot_tick,
  input logic          send_req,
  input logic [QW-1:0] send_quanta,
  input logic          send_done,
  input logic          rx_valid,
  input logic [AW-1:0] rx_da,
  input logic [15:0]   rx_type,
  input logic [15:0]   rx_opcode,
  input logic [QW-1:0] rx_quanta,
  input logic          tx_paused
);
  wire mc_ok = rx_valid & full_duplex & rx_fc_en & (rx_type == 16'h8808) &
               (rx_opcode == 16'h0001) & (rx_da == 48'h0180C2000001);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_req && !send_done |=> send_req && $stable(send_quanta));
  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(send_req) |-> $past(send_done));
  p_busy_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sw_init));
  p_busy_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_fc_en && full_duplex));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mc_ok && rx_quanta != '0 |=> tx_paused);
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_paused && !slot_tick && !rx_valid |=> tx_paused);
  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mc_ok && rx_quanta == '0 |=> !tx_paused);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_paused && !rx_valid |=> !tx_paused);
endmodule

bind pause_flow_ctrl pause_flow_ctrl_chk #(.QW(QW), .AW(AW)) u_chk (.*);

// File: tb/pause_flow_ctrl_test.sv
`timescale 1ns/1ps
module pause_flow_ctrl_test;
  localparam int QW = 16;
  localparam int AW = 48;
  localparam logic [47:0] MC = 48'h0180C2000001;
  localparam logic [47:0] ST = 48'h02AABBCCDDEE;

  logic clk = 0, rst_n = 0;
  logic full_duplex = 1, tx_fc_en = 1, rx_fc_en = 1, uni_pause_en = 0, zq_disable = 0;
  logic [1:0] thr_code = 0;
  logic [QW-1:0] pause_time = 20;
  logic [AW-1:0] station_addr = ST;
  logic sw_init = 0, fifo_fc_req = 0, slot_tick = 0, send_done = 0, rx_valid = 0;
  logic [AW-1:0] rx_da = MC;
  logic [15:0] rx_type = 16'h8808, rx_opcode = 16'h0001;
  logic [QW-1:0] rx_quanta = 0;
  logic busy, send_req, tx_paused;
  logic [QW-1:0] send_quanta;

  int total = 0, bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  pause_flow_ctrl #(.QW(QW), .AW(AW)) uut (.*);

  // behavioural reference
  int m_sreq, m_sq, m_pv, m_pq, m_busy, m_rc, m_fq, m_pc;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sreq = 0; m_sq = 0; m_pv = 0; m_pq = 0; m_busy = 0; m_rc = 0; m_fq = 0; m_pc = 0;
    end else begin
      int en, rise, fall, resend, ins, iq, done, off, swg, acc;
      acc = rx_valid && full_duplex && rx_fc_en && rx_type == 16'h8808 && rx_opcode == 16'h0001 &&
            (rx_da == MC || (uni_pause_en && rx_da == station_addr));
      if (acc) m_pc = int'(rx_quanta);
      else if (slot_tick && m_pc > 0) m_pc = m_pc - 1;
      en = tx_fc_en && full_duplex;
      rise = fifo_fc_req && !m_fq;
      fall = !fifo_fc_req && m_fq;
      resend = slot_tick && m_rc == 1 && fifo_fc_req;
      swg = sw_init && en;
      ins = 0; iq = 0;
      if (swg) begin ins = 1; iq = int'(pause_time); end
      else if ((rise || resend) && en) begin ins = 1; iq = int'(pause_time); end
      else if (fall && en && !zq_disable) begin ins = 1; iq = 0; end
      done = m_sreq && send_done;
      off = (thr_code == 0) ? 4 : (thr_code == 1) ? 28 : (thr_code == 2) ? 144 : 256;
      if (fall) m_rc = 0;
      else if (done && m_sq != 0 && fifo_fc_req && int'(pause_time) > off) m_rc = int'(pause_time) - off;
      else if (done) m_rc = 0;
      else if (slot_tick && m_rc > 0) m_rc = m_rc - 1;
      if (!m_sreq && m_pv) begin m_sreq = 1; m_sq = m_pq; m_pv = 0; end
      else if (done) m_sreq = 0;
      if (ins) begin m_pv = 1; m_pq = iq; end
      if (swg) m_busy = 1;
      else if (done && !m_pv) m_busy = 0;
      m_fq = fifo_fc_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done_flag) begin
    chk(send_req == m_sreq[0], "R3 send_req vs model", send_req, m_sreq);
    if (m_sreq != 0) chk(int'(send_quanta) == m_sq, "R3 send_quanta vs model", send_quanta, m_sq);
    chk(busy == m_busy[0], "R2 busy vs model", busy, m_busy);
    chk(tx_paused == (m_pc != 0), "R8 tx_paused vs model", tx_paused, m_pc != 0);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic pulse_sw();
    sw_init = 1; step(1); sw_init = 0;
  endtask
  task automatic tick();
    slot_tick = 1; step(1); slot_tick = 0;
  endtask
  task automatic finish_frame();
    for (int i = 0; i < 10 && !send_req; i++) step(1);
    send_done = 1; step(1); send_done = 0;
  endtask
  task automatic rx_frame(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                          input int q);
    rx_da = da; rx_type = ty; rx_opcode = op; rx_quanta = QW'(q);
    rx_valid = 1; step(1); rx_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", 0, 1);
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    chk(!send_req && !busy && !tx_paused, "R1 reset state", {send_req, busy, tx_paused}, 0);
    rst_n = 1; step(1);
    chk(!send_req && !busy && !tx_paused, "R1 after release", {send_req, busy, tx_paused}, 0);

    // software initiate
    pause_time = 20; pulse_sw();
    chk(busy, "R2 busy set", busy, 1);
    step(1);
    chk(send_req && send_quanta == 20, "R2 frame carries PT", send_quanta, 20);
    step(5);
    chk(send_req && send_quanta == 20, "R3 request held", send_req, 1);
    chk(busy, "R2 busy while sending", busy, 1);
    finish_frame();
    chk(!busy && !send_req, "R2 busy clears after done", busy, 0);

    // gating
    tx_fc_en = 0; pulse_sw(); step(2);
    chk(!busy && !send_req, "R4 tx flow control off", send_req, 0);
    tx_fc_en = 1; full_duplex = 0; pulse_sw(); fifo_fc_req = 1; step(3);
    chk(!busy && !send_req, "R4 half duplex", send_req, 0);
    fifo_fc_req = 0; step(2); full_duplex = 1; step(1);

    // fifo rise and refresh, code 0: PT=20 -> 16 ticks
    thr_code = 0; fifo_fc_req = 1; step(2);
    chk(send_req && send_quanta == 20, "R5 fifo rise sends PT", send_quanta, 20);
    finish_frame();
    for (int i = 0; i < 15; i++) tick();
    step(2);
    chk(!send_req, "R6 no early refresh code0", send_req, 0);
    tick(); step(1);
    chk(send_req && send_quanta == 20, "R6 refresh at PT-4", send_quanta, 20);
    // code 1: PT=30 -> 2 ticks
    thr_code = 1; pause_time = 30; finish_frame();
    tick(); step(2);
    chk(!send_req, "R6 no early refresh code1", send_req, 0);
    tick(); step(1);
    chk(send_req && send_quanta == 30, "R6 refresh at PT-28", send_quanta, 30);
    // code 2: PT=150 -> 6 ticks
    thr_code = 2; pause_time = 150; finish_frame();
    for (int i = 0; i < 5; i++) tick();
    step(2);
    chk(!send_req, "R6 no early refresh code2", send_req, 0);
    tick(); step(1);
    chk(send_req && send_quanta == 150, "R6 refresh at PT-144", send_quanta, 150);
    // code 3 with PT below offset: no refresh
    thr_code = 3; pause_time = 200; finish_frame();
    for (int i = 0; i < 40; i++) tick();
    step(2);
    chk(!send_req, "R6 no refresh when PT<=offset", send_req, 0);

    // release
    fifo_fc_req = 0; step(2);
    chk(send_req && send_quanta == 0, "R7 zero quanta on release", send_quanta, 0);
    finish_frame();
    fifo_fc_req = 1; step(2); thr_code = 0; pause_time = 10; finish_frame();
    zq_disable = 1; fifo_fc_req = 0; step(1);
    for (int i = 0; i < 12; i++) tick();
    step(2);
    chk(!send_req, "R7 zero quanta suppressed and refresh cancelled", send_req, 0);
    zq_disable = 0;

    // priority: sw_init with fifo fall in same cycle
    fifo_fc_req = 1; step(2); finish_frame();
    fifo_fc_req = 0; sw_init = 1; step(1); sw_init = 0; step(1);
    chk(send_req && send_quanta == 10, "R12 sw wins over release", send_quanta, 10);
    // override pending: in flight PT, queue zero via rise/fall, then sw
    fifo_fc_req = 1; step(1); fifo_fc_req = 0; step(1); pause_time = 7; pulse_sw();
    finish_frame(); step(1);
    chk(send_req && send_quanta == 7, "R12 newer request overwrites pending", send_quanta, 7);
    finish_frame(); step(2);

    // receive side
    rx_frame(MC, 16'h8808, 16'h0001, 5);
    chk(tx_paused, "R8 pause starts", tx_paused, 1);
    for (int i = 0; i < 4; i++) tick();
    chk(tx_paused, "R8 still paused after 4 ticks", tx_paused, 1);
    tick();
    chk(!tx_paused, "R8 pause ends after 5 ticks", tx_paused, 0);
    rx_frame(MC, 16'h0800, 16'h0001, 5);
    chk(!tx_paused, "R11 wrong type", tx_paused, 0);
    rx_frame(MC, 16'h8808, 16'h0002, 5);
    chk(!tx_paused, "R11 wrong opcode", tx_paused, 0);
    rx_frame(48'h0180C2000002, 16'h8808, 16'h0001, 5);
    chk(!tx_paused, "R11 wrong DA", tx_paused, 0);
    rx_fc_en = 0; rx_frame(MC, 16'h8808, 16'h0001, 5);
    chk(!tx_paused, "R11 rx flow control off", tx_paused, 0);
    rx_fc_en = 1; full_duplex = 0; rx_frame(MC, 16'h8808, 16'h0001, 5);
    chk(!tx_paused, "R11 half duplex", tx_paused, 0);
    full_duplex = 1;
    rx_frame(ST, 16'h8808, 16'h0001, 5);
    chk(!tx_paused, "R9 unicast refused", tx_paused, 0);
    uni_pause_en = 1; rx_frame(ST, 16'h8808, 16'h0001, 3);
    chk(tx_paused, "R9 unicast accepted", tx_paused, 1);
    rx_frame(MC, 16'h8808, 16'h0001, 0);
    chk(!tx_paused, "R10 zero quanta ends pause", tx_paused, 0);
    rx_frame(MC, 16'h8808, 16'h0001, 2);
    tick();
    rx_frame(MC, 16'h8808, 16'h0001, 4);
    for (int i = 0; i < 3; i++) tick();
    chk(tx_paused, "R10 reload extends pause", tx_paused, 1);
    tick();
    chk(!tx_paused, "R10 reload count ends", tx_paused, 0);
    rx_frame(MC, 16'h8808, 16'h0001, 3);
    rx_frame(MC, 16'h8808, 16'h0003, 9);
    for (int i = 0; i < 3; i++) tick();
    chk(!tx_paused, "R11 bad frame leaves count unchanged", tx_paused, 0);

    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      sw_init = (r < 3);
      slot_tick = ($urandom_range(0, 3) == 0);
      send_done = send_req && ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 39) == 0) fifo_fc_req = ~fifo_fc_req;
      if ($urandom_range(0, 199) == 0) thr_code = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) pause_time = QW'($urandom_range(1, 40));
      if ($urandom_range(0, 299) == 0) tx_fc_en = ~tx_fc_en;
      if ($urandom_range(0, 299) == 0) zq_disable = ~zq_disable;
      if ($urandom_range(0, 299) == 0) uni_pause_en = ~uni_pause_en;
      full_duplex = ($urandom_range(0, 99) != 0);
      rx_valid = ($urandom_range(0, 29) == 0);
      r = $urandom_range(0, 3);
      rx_da = (r == 0) ? ST : (r == 3) ? 48'h0180C2000003 : MC;
      rx_type = ($urandom_range(0, 7) == 0) ? 16'h0806 : 16'h8808;
      rx_opcode = ($urandom_range(0, 7) == 0) ? 16'h0002 : 16'h0001;
      rx_quanta = QW'($urandom_range(0, 12));
      step(1);
    end
    sw_init = 0; slot_tick = 0; send_done = 0; rx_valid = 0;
    step(2);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule